// File: doc/BRIEF.md
# Modem Handshake Status Register

This block is the modem status byte of a serial port. It watches four active-low handshake inputs from a modem: clear to send, data set ready, ring indicator and carrier detect. The upper nibble of the byte shows the present level of each line, inverted so that a 1 means the line is asserted. The lower nibble holds sticky event flags that record line changes since the CPU last read the byte. A one-cycle read strobe returns the byte and clears the event flags on the next clock edge.

In loopback mode the four levels come from bits of the handshake control register instead of the pins. Change detection then follows those control bits, so software can test the status path without a modem attached. An interrupt-pending output goes high while any event flag is set and the modem-status interrupt enable is high.

Top module: `modem_status_reg`

## Requirements
- R1: Outside loopback, rd_data[7] = NOT dcd_n, rd_data[6] = NOT ri_n, rd_data[5] = NOT dsr_n and rd_data[4] = NOT cts_n. Each pin passes through a two-flop synchronizer, so a pin change appears on these bits after the third rising clock edge.
- R2: When loop_en was high in the previous cycle, rd_data[7] = hctl[3], rd_data[6] = hctl[2], rd_data[5] = hctl[0] and rd_data[4] = hctl[1], each one clock after the control bit changes.
- R3: rd_data[3] is set when the carrier detect level changes in either direction.
- R4: rd_data[2] is set only when the ring line goes inactive, which means the ri_n pin rises and rd_data[6] falls. A ring line going active does not set it.
- R5: rd_data[1] is set on any change of the data set ready level, and rd_data[0] on any change of the clear to send level.
- R6: While rd_stb is high, rd_data shows the current byte. At the following clock edge rd_data[3:0] are cleared and rd_data[7:4] are left unchanged.
- R7: A line event detected at the same clock edge that ends a read still sets its flag, so the event is not lost.
- R8: In loopback the pins have no effect on rd_data, and change flags follow the looped-back control bits. Turning loopback on or off sets the flag of every level that differs between the two sources.
- R9: irq_pend is high exactly when irq_en is high and at least one of rd_data[3:0] is set.
- R10: Synchronous reset clears all flags and preloads the synchronizers and the level history with the current input levels. Lines that are already asserted during reset therefore raise no flag after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | CPU read strobe, one cycle per read |
| rd_data | output | 8 | Status byte: levels in [7:4], event flags in [3:0] |
| cts_n | input | 1 | Clear to send pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| loop_en | input | 1 | Loopback mode enable |
| hctl | input | 4 | Handshake control register bits that are looped back |
| irq_en | input | 1 | Modem-status interrupt enable |
| irq_pend | output | 1 | Modem-status interrupt pending |

## Verification
The bench drives the ring line in both directions, in normal mode and in loopback. A design that flags every ring change, or flags the wrong direction, reports an edge that should have been ignored. It places a pin event on exactly the clock edge that ends a read. A design that lets the read-clear win at that edge drops the event, and the next read comes back empty. It also changes the loopback routing, toggles pins while loopback is on, switches loopback off, and resets while lines are held asserted. A design that routes the wrong control bits, lets the pins leak through in loopback, or loses its edge history at reset shows wrong levels or false flags.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int NLINES      = 4;
    localparam int SYNC_STAGES = 2;

    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    typedef logic [NLINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t level;
        line_vec_t flag;
    } status_t;

    typedef enum logic {
        EDGE_ANY,
        EDGE_FALL
    } edge_kind_e;

    function automatic int loop_src(input int idx);
        case (idx)
            IDX_CTS: return 1;
            IDX_DSR: return 0;
            default: return idx;
        endcase
    endfunction

    function automatic edge_kind_e edge_kind(input int idx);
        return (idx == IDX_RI) ? EDGE_FALL : EDGE_ANY;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= din;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/msr_level_sel.sv
module msr_level_sel
    import msr_pkg::*;
(
    input  line_vec_t pin_n,
    input  logic      loop_en,
    input  line_vec_t hctl,
    output line_vec_t lvl
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        localparam int SRC = loop_src(i);
        assign lvl[i] = loop_en ? hctl[SRC] : ~pin_n[i];
    end
endmodule

// File: rtl/msr_flag_bank.sv
module msr_flag_bank
    import msr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_stb,
    input  line_vec_t lvl,
    input  line_vec_t lvl_init,
    output status_t   stat
);
    line_vec_t lvl_q, flag_q, evt;

    for (genvar i = 0; i < NLINES; i++) begin : g_evt
        if (edge_kind(i) == EDGE_FALL) begin : g_fall
            assign evt[i] = lvl_q[i] & ~lvl[i];
        end else begin : g_any
            assign evt[i] = lvl_q[i] ^ lvl[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= lvl_init;
            flag_q <= '0;
        end else begin
            lvl_q  <= lvl;
            flag_q <= (rd_stb ? '0 : flag_q) | evt;
        end
    end

    assign stat.level = lvl_q;
    assign stat.flag  = flag_q;
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import msr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_stb,
    output logic [7:0] rd_data,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    input  logic       loop_en,
    input  logic [3:0] hctl,
    input  logic       irq_en,
    output logic       irq_pend
);
    line_vec_t pin_raw, pin_sync, lvl_run, lvl_rst;
    status_t   stat;

    always_comb begin
        pin_raw          = '0;
        pin_raw[IDX_CTS] = cts_n;
        pin_raw[IDX_DSR] = dsr_n;
        pin_raw[IDX_RI]  = ri_n;
        pin_raw[IDX_DCD] = dcd_n;
    end

    msr_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_raw),
        .dout (pin_sync)
    );

    msr_level_sel u_sel_run (
        .pin_n   (pin_sync),
        .loop_en (loop_en),
        .hctl    (hctl),
        .lvl     (lvl_run)
    );

    msr_level_sel u_sel_rst (
        .pin_n   (pin_raw),
        .loop_en (loop_en),
        .hctl    (hctl),
        .lvl     (lvl_rst)
    );

    msr_flag_bank u_flags (
        .clk      (clk),
        .rst      (rst),
        .rd_stb   (rd_stb),
        .lvl      (lvl_run),
        .lvl_init (lvl_rst),
        .stat     (stat)
    );

    assign rd_data  = stat;
    assign irq_pend = irq_en & (|stat.flag);
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       loop_en,
    input logic [3:0] hctl,
    input logic       irq_en,
    input logic       irq_pend
);
    p_irq_r9: assert property (@(posedge clk) disable iff (rst)
        irq_pend == (irq_en && (rd_data[3:0] != 4'h0)));

    p_loop_levels_r2: assert property (@(posedge clk) disable iff (rst)
        $past(loop_en) |-> rd_data[7:4] ==
            {$past(hctl[3]), $past(hctl[2]), $past(hctl[0]), $past(hctl[1])});

    p_dcd_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_data[7] != $past(rd_data[7])) |-> rd_data[3]);

    p_ri_inactive_only_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[2]) |-> ($past(rd_data[6]) && !rd_data[6]));

    p_dsr_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_data[5] != $past(rd_data[5])) |-> rd_data[1]);

    p_cts_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_data[4] != $past(rd_data[4])) |-> rd_data[0]);

    p_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> ((rd_data[3:0] & ~(rd_data[7:4] ^ $past(rd_data[7:4]))) == 4'h0));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));
endmodule

bind modem_status_reg msr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .loop_en  (loop_en),
    .hctl     (hctl),
    .irq_en   (irq_en),
    .irq_pend (irq_pend)
);

// File: tb/modem_status_reg_test.sv
module modem_status_reg_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       loop_en = 1'b0;
    logic [3:0] hctl = 4'h0;
    logic       irq_en = 1'b0;
    logic       irq_pend;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    modem_status_reg uut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_data(rd_data),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .loop_en(loop_en), .hctl(hctl), .irq_en(irq_en), .irq_pend(irq_pend)
    );

    // monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_stb) begin
            exp_t e;
            n_run++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL %s: unexpected read, data=%02h", "R6", rd_data);
            end else begin
                e = sb.pop_front();
                if (rd_data !== e.data || irq_pend !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: data=%02h irq=%0b expected data=%02h irq=%0b",
                             e.tag, rd_data, irq_pend, e.data, e.irq);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [7:0] d, input logic irq, input string tag);
        exp_t e;
        e.data = d; e.irq = irq; e.tag = tag;
        sb.push_back(e);
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(2);
    endtask

    initial begin
        step(1);
        do_reset();
        rd(8'h00, 1'b0, "R10 idle after reset");

        cts_n = 1'b0; step(5);
        rd(8'h11, 1'b0, "R1 R5 cts asserted, irq masked R9");
        rd(8'h10, 1'b0, "R6 flag cleared after read");

        dsr_n = 1'b0; step(5);
        rd(8'h32, 1'b0, "R5 dsr asserted");

        ri_n = 1'b0; step(5);
        rd(8'h70, 1'b0, "R4 ring going active sets no flag");
        ri_n = 1'b1; step(5);
        rd(8'h34, 1'b0, "R4 ring going inactive sets flag");
        rd(8'h30, 1'b0, "R6 ring flag cleared");

        dcd_n = 1'b0; step(5);
        rd(8'hB8, 1'b0, "R3 carrier asserted");
        dcd_n = 1'b1; step(5);
        rd(8'h38, 1'b0, "R3 carrier deasserted");

        irq_en = 1'b1;
        cts_n = 1'b1; step(5);
        rd(8'h21, 1'b1, "R9 irq with flag");
        rd(8'h20, 1'b0, "R9 irq drops after read clear");

        // R7: event lands on the edge that ends a read
        dsr_n = 1'b1; step(2);
        rd(8'h20, 1'b0, "R7 read before event");
        step(2);
        rd(8'h02, 1'b1, "R7 event kept across read");
        rd(8'h00, 1'b0, "R6 cleared");

        loop_en = 1'b1; step(3);
        rd(8'h00, 1'b0, "R8 loop on with equal levels");
        hctl = 4'b0010; step(3);
        rd(8'h11, 1'b1, "R2 hctl1 to cts level");
        hctl = 4'b1001; step(3);
        rd(8'hAB, 1'b1, "R2 R8 hctl3 hctl0 routing");
        hctl = 4'b1101; step(3);
        rd(8'hE0, 1'b0, "R4 loopback ring active no flag");
        hctl = 4'b1001; step(3);
        rd(8'hA4, 1'b1, "R4 loopback ring inactive flag");
        cts_n = 1'b0; ri_n = 1'b0; step(5);
        rd(8'hA0, 1'b0, "R8 pins ignored in loopback");
        ri_n = 1'b1; step(5);

        loop_en = 1'b0; step(3);
        rd(8'h1B, 1'b1, "R8 loop off sets flags");

        dcd_n = 1'b0;
        do_reset();
        rd(8'h90, 1'b0, "R10 held lines raise no flag");

        step(2);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R6: %0d reads not observed, expected 0", sb.size());
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule